// File: doc/BRIEF.md
# Configuration Access Translator

This block sits between a simple memory-mapped slave bus and a downstream configuration port. Software programs a 32-bit index register through one 4 KiB window. It then reads or writes a second 4 KiB window whose low address bits give a byte offset. Each data-window access becomes one configuration request. The request carries a packed address, right-justified data, a byte size and a direction. The slave access stalls until the downstream port answers with ready.

The index register is decoded in one of three formats. If the top bit is set, the index passes through. If only the low bit is set, the index passes through in the classic type-1 form. Otherwise the index is a type-0 form: a one-hot device-select field in the upper bits is converted to a device number, taken as the position of its lowest set bit, and packed together with the function number and the register offset. The block also routes a set of per-slot legacy interrupt pins onto four shared lines, rotating each slot's pins by its device number.

Top module: `cfg_xlate_bridge`

## Requirements
- R1: The index register is 32 bits wide and holds the last full word written through the index window. A read of the index window returns that value. After reset the value is zero.
- R2: When index bit 31 is 1, the request address is the index with bits 1:0 replaced by data-window address bits 1:0. This check takes priority over R3 and R4.
- R3: When index bit 31 is 0 and bit 0 is 1, the request address is the index with bits 2:0 replaced by data-window address bits 2:0.
- R4: When index bits 31 and 0 are both 0, the request address is built as follows. Bits 15:11 hold the bit position (11 to 31) of the lowest set bit among index bits 31:11. Bits 10:8 hold index bits 10:8, which is the function. Bits 7:3 hold index bits 7:3. Bits 2:0 hold data-window address bits 2:0. Bits 31:16 are zero, and index bits 2:0 are ignored.
- R5: In the R4 format with index bits 31:11 all zero, there is no device. A read completes with data 0xFFFFFFFF, and a write completes without any downstream request.
- R6: A request stays asserted with a stable address and stable data until cfg_ready is seen. bus_done then pulses for one cycle on the next clock. So an access with a downstream latency of L cycles takes L+2 cycles from acceptance to observed completion.
- R7: The byte-size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes, and cfg_size carries the same code. Write data goes downstream shifted right by 8×(address bits 1:0) and masked to the size. Read data comes back masked to the size and shifted left by 8×(address bits 1:0).
- R8: The interrupt pin p of slot s is at irq_in[4*s+p]. It drives line (p+s) mod 4 of irq_out. Each line is the registered OR of its sources and follows them one clock later.
- R9: After reset, no request is pending, bus_done is low and every interrupt line is low.
- R10: Address bit 12 selects the window: 0 for index, 1 for data. Bits 11:3 are ignored in both windows. An index-window access never raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request, held until bus_done |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; top bit selects window |
| bus_size | input | 2 | Size code (0:1B, 1:2B, 2:4B) |
| bus_wdata | input | 32 | Lane-aligned write data |
| bus_rdata | output | 32 | Lane-aligned read data |
| bus_done | output | 1 | One-cycle completion pulse |
| cfg_req | output | 1 | Downstream request |
| cfg_wr | output | 1 | Request direction |
| cfg_addr | output | 32 | Packed configuration address |
| cfg_size | output | 2 | Request size code |
| cfg_wdata | output | 32 | Right-justified write data |
| cfg_ready | input | 1 | Downstream accepts/answers request |
| cfg_rdata | input | 32 | Right-justified read data |
| irq_in | input | NSLOT*4 | Per-slot interrupt pins |
| irq_out | output | 4 | Shared interrupt lines |

## Verification
Eight index values are translated through one byte read each. Together they cover the pass-through form, the type-1 form and single and multiple device bits in the type-0 form. They also cover index values with both bit 31 and bit 0 set, which shows the decoder applies the right priority, and type-0 values with junk in index bits 2:0, which shows those bits are dropped. Separate halfword and word accesses at non-zero lanes show the lane shifting and masking in both directions. Empty device-select reads and writes show the all-ones and no-request behaviour. Interrupts are driven from several slots and pins, so that a wrong rotation lands on a different line.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  localparam int DATA_W = 32;
  localparam int DEV_W  = 5;
  localparam int FN_W   = 3;
  localparam int DEV_LSB = 11;
  localparam int NLINE  = 4;

  typedef enum logic {ST_IDLE, ST_WAIT} st_t;

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/cfg_lsb_find.sv
module cfg_lsb_find #(
  parameter int W = 21,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          found
);
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        pos   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
  import cfg_xlate_pkg::*;
(
  input  logic [31:0] idx,
  input  logic [2:0]  off,
  output logic [31:0] addr,
  output logic        no_dev
);
  localparam int SEL_W = 32 - DEV_LSB;
  localparam int PW    = $clog2(SEL_W);

  logic [PW-1:0]    pos;
  logic             found;
  logic [DEV_W-1:0] dev;

  cfg_lsb_find #(.W(SEL_W)) u_find (
    .vec   (idx[31:DEV_LSB]),
    .pos   (pos),
    .found (found)
  );

  always_comb begin
    dev    = found ? DEV_W'(pos) + DEV_W'(DEV_LSB) : '1;
    no_dev = 1'b0;
    if (idx[31]) begin
      addr = {idx[31:2], off[1:0]};
    end else if (idx[0]) begin
      addr = {idx[31:3], off};
    end else begin
      addr   = {16'h0, dev, idx[10:8], idx[7:3], off};
      no_dev = !found;
    end
  end
endmodule

// File: rtl/cfg_irq_swizzle.sv
module cfg_irq_swizzle
  import cfg_xlate_pkg::*;
#(
  parameter int NSLOT = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSLOT*NLINE-1:0] irq_in,
  output logic [NLINE-1:0]       irq_out
);
  logic [NLINE-1:0] nxt;

  always_comb begin
    nxt = '0;
    for (int s = 0; s < NSLOT; s++)
      for (int p = 0; p < NLINE; p++)
        nxt[(s + p) % NLINE] = nxt[(s + p) % NLINE] | irq_in[s*NLINE + p];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= nxt;
  end
endmodule

// File: rtl/cfg_xlate_bridge.sv
module cfg_xlate_bridge
  import cfg_xlate_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int NSLOT  = 8,
  localparam int SEL   = ADDR_W - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [1:0]             bus_size,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   bus_done,
  output logic                   cfg_req,
  output logic                   cfg_wr,
  output logic [31:0]            cfg_addr,
  output logic [1:0]             cfg_size,
  output logic [DATA_W-1:0]      cfg_wdata,
  input  logic                   cfg_ready,
  input  logic [DATA_W-1:0]      cfg_rdata,
  input  logic [NSLOT*NLINE-1:0] irq_in,
  output logic [NLINE-1:0]       irq_out
);
  st_t         state;
  logic [31:0] idx_q;
  logic [1:0]  lane_q;
  logic [31:0] xl_addr;
  logic        xl_no_dev;
  logic        accept;

  cfg_addr_xlate u_xlate (
    .idx    (idx_q),
    .off    (bus_addr[2:0]),
    .addr   (xl_addr),
    .no_dev (xl_no_dev)
  );

  cfg_irq_swizzle #(.NSLOT(NSLOT)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .irq_out (irq_out)
  );

  assign accept = (state == ST_IDLE) && bus_valid && !bus_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx_q     <= '0;
      lane_q    <= '0;
      bus_rdata <= '0;
      bus_done  <= 1'b0;
      cfg_req   <= 1'b0;
      cfg_wr    <= 1'b0;
      cfg_addr  <= '0;
      cfg_size  <= '0;
      cfg_wdata <= '0;
    end else begin
      bus_done <= 1'b0;
      if (accept) begin
        if (!bus_addr[SEL]) begin
          if (bus_write) idx_q <= bus_wdata;
          else           bus_rdata <= idx_q;
          bus_done <= 1'b1;
        end else if (xl_no_dev) begin
          if (!bus_write) bus_rdata <= '1;
          bus_done <= 1'b1;
        end else begin
          cfg_req   <= 1'b1;
          cfg_wr    <= bus_write;
          cfg_addr  <= xl_addr;
          cfg_size  <= bus_size;
          cfg_wdata <= (bus_wdata >> {bus_addr[1:0], 3'b000}) & size_mask(bus_size);
          lane_q    <= bus_addr[1:0];
          state     <= ST_WAIT;
        end
      end else if (state == ST_WAIT && cfg_ready) begin
        cfg_req  <= 1'b0;
        bus_done <= 1'b1;
        if (!cfg_wr)
          bus_rdata <= (cfg_rdata & size_mask(cfg_size)) << {lane_q, 3'b000};
        state <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
  parameter int ADDR_W = 13,
  parameter int NSLOT  = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_valid,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_done,
  input logic                cfg_req,
  input logic                cfg_ready,
  input logic [31:0]         cfg_addr,
  input logic [31:0]         cfg_wdata,
  input logic [NSLOT*4-1:0]  irq_in,
  input logic [3:0]          irq_out
);
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_req && !cfg_ready |=> cfg_req && $stable(cfg_addr) && $stable(cfg_wdata));

  assert_done_after_ready_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_req && cfg_ready |=> bus_done && !cfg_req);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    bus_done |=> !bus_done);

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !cfg_req && !bus_done && irq_out == 4'h0);

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    irq_in == '0 |=> irq_out == 4'h0);

  assert_irq_active_R8: assert property (@(posedge clk) disable iff (rst)
    irq_in != '0 |=> irq_out != 4'h0);

  assert_index_no_req_R10: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_addr[ADDR_W-1] && !cfg_req |=> !cfg_req);
endmodule

bind cfg_xlate_bridge cfg_xlate_chk #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_addr  (bus_addr),
  .bus_done  (bus_done),
  .cfg_req   (cfg_req),
  .cfg_ready (cfg_ready),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .irq_in    (irq_in),
  .irq_out   (irq_out)
);

// File: tb/sim_cfg_xlate_bridge.sv
`timescale 1ns/1ps
module sim_cfg_xlate_bridge;
  localparam int ADDR_W = 13;
  localparam int NSLOT  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [1:0]        bus_size = '0;
  logic [31:0]       bus_wdata = '0, bus_rdata;
  logic              bus_done, cfg_req, cfg_wr, cfg_ready = 1'b0;
  logic [31:0]       cfg_addr, cfg_wdata, cfg_rdata = '0;
  logic [1:0]        cfg_size;
  logic [NSLOT*4-1:0] irq_in = '0;
  logic [3:0]        irq_out;

  always #2 clk = ~clk;

  cfg_xlate_bridge #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u0 (.*);

  int checks = 0, errors = 0, lat = 0;
  bit finished = 0;
  logic [31:0] t_rd, t_addr, t_wdata;
  logic        t_got, t_wr;
  logic [1:0]  t_size;
  int          t_iters;

  // idx[66:35], off[34:32], expected address[31:0]
  localparam logic [66:0] VEC [0:7] = '{
    {32'h8000_1234, 3'd7, 32'h8000_1237},  // R2
    {32'h0001_2305, 3'd6, 32'h0001_2306},  // R3
    {32'h0000_0800, 3'd0, 32'h0000_5800},  // R4
    {32'h0001_0548, 3'd2, 32'h0000_854A},  // R4
    {32'h4004_03FC, 3'd5, 32'h0000_93FD},  // R4
    {32'h4000_0000, 3'd1, 32'h0000_F001},  // R4
    {32'h8000_0001, 3'd2, 32'h8000_0002},  // R2 priority
    {32'h00AB_CD07, 3'd0, 32'h00AB_CD00}   // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [31:0] resp);
    int wcnt = 0;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    t_got = 1'b0; t_iters = 0;
    forever begin
      @(negedge clk);
      t_iters++;
      if (bus_done) begin t_rd = bus_rdata; break; end
      if (cfg_req) begin
        if (!t_got) begin
          t_got = 1'b1; t_addr = cfg_addr; t_wdata = cfg_wdata; t_wr = cfg_wr; t_size = cfg_size;
        end
        if (wcnt == lat) begin cfg_ready = 1'b1; cfg_rdata = resp; end
        wcnt++;
      end else cfg_ready = 1'b0;
      if (t_iters > 100) begin
        errors++; $display("FAIL R6 access timeout act=0 exp=1"); break;
      end
    end
    bus_valid = 1'b0; cfg_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 req after reset", 32'(cfg_req), 0);
    chk("R9 done after reset", 32'(bus_done), 0);
    chk("R9 irq after reset", 32'(irq_out), 0);
    access(0, 13'h0000, 2'd2, 0, 0);
    chk("R1 index reset value", t_rd, 32'h0);

    // vector table: R2 R3 R4 decoding, R7 byte lane on read
    for (int i = 0; i < 8; i++) begin
      access(1, 13'h0000, 2'd2, VEC[i][66:35], 0);
      access(0, {1'b1, 9'h0, VEC[i][34:32]}, 2'd0, 0, 32'h0000_00A5);
      chk("R2 R3 R4 request seen", 32'(t_got), 1);
      chk("R2 R3 R4 address", t_addr, VEC[i][31:0]);
      chk("R7 byte read lane", t_rd, 32'h0000_00A5 << (8 * VEC[i][33:32]));
    end

    // R1 read back
    access(1, 13'h0000, 2'd2, 32'h1234_5678, 0);
    access(0, 13'h0000, 2'd2, 0, 0);
    chk("R1 index readback", t_rd, 32'h1234_5678);
    // R10 upper offset bits ignored in index window, no request
    access(0, 13'h0FFC, 2'd2, 0, 0);
    chk("R10 index alias", t_rd, 32'h1234_5678);
    chk("R10 no request on index", 32'(t_got), 0);

    // R5 empty device select
    access(1, 13'h0000, 2'd2, 32'h0000_0700, 0);
    access(0, 13'h1000, 2'd2, 0, 32'h1111_1111);
    chk("R5 no-dev read data", t_rd, 32'hFFFF_FFFF);
    chk("R5 no-dev read no req", 32'(t_got), 0);
    access(1, 13'h1000, 2'd2, 32'hDEAD_BEEF, 0);
    chk("R5 no-dev write no req", 32'(t_got), 0);

    // R7 halfword write at lane 2, R10 high offset bits ignored in data window
    access(1, 13'h0000, 2'd2, 32'h0000_1000, 0);
    access(1, 13'h1FFA, 2'd1, 32'hBEEF_CAFE, 0);
    chk("R7 write data right-justified", t_wdata, 32'h0000_BEEF);
    chk("R7 write size code", 32'(t_size), 1);
    chk("R7 write direction", 32'(t_wr), 1);
    chk("R10 data offset from low bits", t_addr, 32'h0000_6002);
    access(0, 13'h1002, 2'd1, 0, 32'h1234_ABCD);
    chk("R7 halfword read lane", t_rd, 32'hABCD_0000);
    access(0, 13'h1004, 2'd2, 0, 32'h89AB_CDEF);
    chk("R7 word read", t_rd, 32'h89AB_CDEF);

    // R6 stall length
    lat = 5;
    access(0, 13'h1000, 2'd2, 0, 32'h5555_AAAA);
    chk("R6 stall cycles", 32'(t_iters), 32'd7);
    chk("R6 data after stall", t_rd, 32'h5555_AAAA);
    lat = 0;
    access(0, 13'h1000, 2'd2, 0, 32'h1);
    chk("R6 zero-latency cycles", 32'(t_iters), 32'd2);

    // R8 interrupt swizzle
    irq_in = '0; irq_in[4*3 + 2] = 1'b1;
    @(negedge clk);
    chk("R8 slot3 pin2", 32'(irq_out), 32'h2);
    irq_in = '0; irq_in[4*5 + 0] = 1'b1; irq_in[4*0 + 3] = 1'b1;
    @(negedge clk);
    chk("R8 slot5 pin0 + slot0 pin3", 32'(irq_out), 32'hA);
    irq_in = '0; irq_in[4*7 + 1] = 1'b1;
    @(negedge clk);
    chk("R8 slot7 pin1", 32'(irq_out), 32'h1);
    irq_in = '0;
    @(negedge clk);
    chk("R8 release", 32'(irq_out), 32'h0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule